// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block produces a periodic interrupt for a real-time clock. A free-running tick at 256 Hz advances an internal binary divider. A three-bit rate field in a byte-wide control register selects one of six event rates: 256, 64, 16, 4, 2 or 1 Hz. The field can also select no rate. At each boundary of the chosen period the block sets a sticky pending flag. While that flag is set and a rate is active, the interrupt line is high.

The pending flag, the rate field, a divider-clear bit and a run bit share one control byte. Software reads the byte back to see which event is pending, and it clears the flag by writing a 0 to that bit. The divider advances only while the run bit is set. Writing a new rate, or writing 1 to the divider-clear bit, restarts the count from zero.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset the control byte reads 8'h00 and `irq` is low.
- R2: Control byte layout: bit 7 is the pending flag, bits 6:4 are the rate field, bit 1 is the divider-clear bit, bit 0 is the run bit, and bits 3:2 read as 0. With rate code 3'b001 and run set, every tick sets the pending flag.
- R3: Rate codes 3'b010, 3'b011, 3'b100, 3'b101 and 3'b110 set the flag every 4, 16, 64, 128 and 256 ticks.
- R4: Writing 0 to bit 7 clears the pending flag. Writing 1 to bit 7 leaves the flag unchanged.
- R5: If a period boundary and a write that clears the flag fall in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when the pending flag is set and the rate code is neither 3'b000 nor 3'b111. A set flag under those two codes is kept but gives no interrupt.
- R7: Rate codes 3'b000 and 3'b111 never set the pending flag.
- R8: A write that changes the rate code restarts the divider, so the first event comes one full new period after the write.
- R9: While the run bit is 0, ticks neither advance the divider nor set the flag. After the run bit is set again, counting resumes from the held divider value.
- R10: Writing 1 to bit 1 clears the divider, so the next event comes a full period later. Bit 1 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the 256 Hz base rate |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Value written to the control byte |
| rd_data | output | 8 | Current value of the control byte |
| irq | output | 1 | Periodic interrupt request |

## Verification
Each active rate code is measured from a freshly restarted divider. The bench counts ticks to the first event and, for the fastest rates, to the next event as well. This separates the six period lengths from one another and from a divider that was not restarted. The rate is also switched partway through a long period, which shows whether a rate change really restarts the count. Stopping the divider partway through a period, and clearing it partway through a period, check that the count holds and that it clears. A tick and a flag-clearing write are driven in the same cycle to show which of the two wins. The two idle codes, 3'b000 and 3'b111, are each given a full slow period of ticks to confirm that no event is raised.

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam logic [2:0] SEL_OFF  = 3'd0;
  localparam logic [2:0] SEL_OFF2 = 3'd7;

  logic [DIV_W-1:0] div_q, mask;
  logic [2:0]       sel_q;
  logic             run_q, flag_q;

  always_comb begin
    case (sel_q)
      3'd1:    mask = DIV_W'(0);
      3'd2:    mask = DIV_W'(3);
      3'd3:    mask = DIV_W'(15);
      3'd4:    mask = DIV_W'(63);
      3'd5:    mask = DIV_W'(127);
      3'd6:    mask = DIV_W'(255);
      default: mask = '0;
    endcase
  end

  wire sel_ok  = (sel_q != SEL_OFF) && (sel_q != SEL_OFF2);
  wire sel_chg = wr_en && (wr_data[6:4] != sel_q);
  wire div_clr = wr_en && (wr_data[1] || sel_chg);
  wire step    = tick && run_q;
  wire hit     = step && sel_ok && !div_clr && ((div_q & mask) == mask);
  wire sw_clr  = wr_en && !wr_data[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      sel_q  <= SEL_OFF;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (div_clr)   div_q <= '0;
      else if (step) div_q <= div_q + 1'b1;
      if (wr_en) begin
        sel_q <= wr_data[6:4];
        run_q <= wr_data[0];
      end
      flag_q <= hit | (flag_q & ~sw_clr);
    end
  end

  assign rd_data = {flag_q, sel_q, 3'b000, run_q};
  assign irq     = flag_q & sel_ok;
endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq
);
  AST_FAST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6:4] == 3'd1 && rd_data[0] && tick && !wr_en) |=> rd_data[7]); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !wr_en) |=> rd_data[7]); // R4
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7] && !tick) |=> !rd_data[7]); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_data[0] && rd_data[6:4] == 3'd1 && wr_en && wr_data[6:4] == 3'd1 && !wr_data[1]) |=> rd_data[7]); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data[7]); // R6
  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[6:4] == 3'd0 || rd_data[6:4] == 3'd7) && !wr_en && !rd_data[7]) |=> !rd_data[7]); // R7
  AST_STOPPED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[0] && !wr_en && !rd_data[7]) |=> !rd_data[7]); // R9
  AST_CLR_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_data[1]); // R10
endmodule

bind periodic_irq_gen periodic_irq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_periodic_irq_gen.sv
module sim_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  periodic_irq_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic measure(output int k);
    k = 0;
    for (int i = 1; i <= 300; i++) begin
      pulse();
      if (rd_data[7]) begin k = i; break; end
    end
  endtask

  task automatic start_sel(input logic [2:0] s);
    wr(8'h01);
    wr({1'b0, s, 4'b0001});
  endtask

  task automatic t_reset();
    check(rd_data == 8'h00, "R1", rd_data, 0);
    check(irq == 1'b0, "R1", irq, 0);
  endtask

  task automatic t_fast();
    int k;
    start_sel(3'd1);
    check(rd_data == 8'h11, "R2", rd_data, 8'h11);
    measure(k); check(k == 1, "R2", k, 1);
    wr(8'h11); measure(k); check(k == 1, "R2", k, 1);
  endtask

  task automatic t_rates();
    int k;
    int per[7] = '{0, 1, 4, 16, 64, 128, 256};
    for (int s = 2; s <= 6; s++) begin
      start_sel(3'(s));
      measure(k); check(k == per[s], "R3", k, per[s]);
    end
    wr(8'h21); measure(k); check(k == 4, "R3", k, 4);
  endtask

  task automatic t_restart();
    int k;
    start_sel(3'd6);
    pulses(100);
    wr(8'h51);
    measure(k); check(k == 128, "R8", k, 128);
  endtask

  task automatic t_clear();
    start_sel(3'd1); pulse();
    wr(8'h91); check(rd_data[7] == 1'b1, "R4", rd_data[7], 1);
    wr(8'h11); check(rd_data[7] == 1'b0, "R4", rd_data[7], 0);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check(rd_data[7] == 1'b1, "R5", rd_data[7], 1);
  endtask

  task automatic t_irq();
    start_sel(3'd1); pulse();
    check(irq == 1'b1, "R6", irq, 1);
    wr(8'h81);
    check(irq == 1'b0 && rd_data[7], "R6", irq, 0);
    wr(8'hF1);
    check(irq == 1'b0 && rd_data[7], "R6", irq, 0);
    wr(8'h01);
    check(irq == 1'b0 && !rd_data[7], "R6", irq, 0);
  endtask

  task automatic t_idle();
    wr(8'h01); pulses(260);
    check(rd_data[7] == 1'b0, "R7", rd_data[7], 0);
    wr(8'h71); pulses(260);
    check(rd_data[7] == 1'b0 && irq == 1'b0, "R7", rd_data[7], 0);
  endtask

  task automatic t_stop();
    start_sel(3'd2); pulses(2);
    wr(8'h20); pulses(10);
    check(rd_data[7] == 1'b0, "R9", rd_data[7], 0);
    wr(8'h21); pulse();
    check(rd_data[7] == 1'b0, "R9", rd_data[7], 0);
    pulse();
    check(rd_data[7] == 1'b1, "R9", rd_data[7], 1);
  endtask

  task automatic t_prerst();
    int k;
    start_sel(3'd6); pulses(100);
    wr(8'h63);
    check(rd_data == 8'h61, "R10", rd_data, 8'h61);
    measure(k); check(k == 256, "R10", k, 256);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast();
    t_rates();
    t_restart();
    t_clear();
    t_irq();
    t_idle();
    t_stop();
    t_prerst();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule